// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Recorder

The recorder watches three already-synchronized digital lines and logs every transition it is armed for. Each log entry names the channel (1, 2 or 3) and carries a 32-bit time stamp made of a 16-bit tick count and a 16-bit count of tick roll-overs. Entries for falling transitions and entries for rising transitions are written to two separate capture tables of 192 entries each. Each table has its own write index. A running total of accepted transitions is available at all times.

Each channel looks for only one direction at a time and swaps that direction after every capture. A configuration byte per channel is latched at the end of every clear. The byte enables the channel and picks the direction of its first expected edge. The time base stays at zero until the first accepted edge after a clear. That edge is stamped wrap 0, tick 0, and from then on the tick counter advances once per clock. Software reads either table through a combinational read port.

Control is a three-state machine. The states are `ST_CLEAR`, `ST_ARM` and `ST_RUN`.
- `ST_CLEAR` zeroes one entry of both tables per cycle. Reset enters it, and so does the `clear` strobe from any state, including `ST_CLEAR` itself, which restarts the sweep.
- After the last entry is zeroed, the configuration is latched and the machine moves to `ST_ARM`. Here the time base is held at zero.
- The first accepted edge moves the machine to `ST_RUN`, where the time base counts.
- `ST_RUN` leaves only on `clear`.

Top module: `edge_stamp_recorder`

## Requirements
- R1: After reset or a `clear` strobe, `busy` is high for 192 cycles while the tables are swept. Afterwards every entry of both tables reads zero, `event_total` is 0, and both overflow flags are low.
- R2: At the end of each sweep, each channel latches its configuration byte. Channel k+1 uses `cfg_bus[8k+7:8k]`. Bit 7 enables the channel. Bit 6 arms a rising first edge, bit 5 arms a falling first edge, and bit 6 wins when both are set. With neither bit set, the channel keeps its previous direction. Changing `cfg_bus` between sweeps has no effect.
- R3: A disabled channel never writes a record and never adds to `event_total`.
- R4: Tick and wrap stay at zero until the first accepted edge after a clear. That edge is stamped wrap 0, tick 0. An edge accepted d cycles later is stamped with tick = d mod 65536.
- R5: The wrap count increments each time the tick counter rolls from 0xFFFF to 0.
- R6: After each accepted edge, a channel swaps its armed direction. Transitions in the other direction are ignored.
- R7: Records of falling edges go to table 0 and records of rising edges go to table 1, selected by `rd_table`. Each table fills from index 0 upward in write order. The channel field holds 1, 2 or 3.
- R8: Edges accepted in the same cycle share one stamp and are written one per cycle, channel 1 first. A channel whose record is still pending ignores further edges.
- R9: Once a table holds 192 records, further records for it are dropped and its overflow flag (`ovf_fall` or `ovf_rise`) is set. The flag stays set until the next clear.
- R10: `event_total` counts every accepted edge, including those dropped by a full table.
- R11: Transitions that occur while `busy` is high are ignored.
- R12: A read address of 192 or above returns all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Strobe that restarts the sweep and configuration load |
| ch_in | input | 3 | Synchronized channel lines, bit k is channel k+1 |
| cfg_bus | input | 24 | Three configuration bytes, byte k for channel k+1 |
| rd_table | input | 1 | Table select: 0 falling, 1 rising |
| rd_addr | input | 8 | Entry index to read |
| busy | output | 1 | High while the tables are being swept |
| rd_chan | output | 2 | Channel id of the addressed entry |
| rd_wrap | output | 16 | Wrap count of the addressed entry |
| rd_tick | output | 16 | Tick value of the addressed entry |
| event_total | output | 16 | Accepted edges since the last clear |
| ovf_fall | output | 1 | Falling table dropped at least one record |
| ovf_rise | output | 1 | Rising table dropped at least one record |

## Verification
A wrong armed direction or enable latch shows up as soon as the next transition on that channel. A record appears in the wrong table, or in no table, and `event_total` is off by one as early as the cycle after the edge. A time base that started early or skipped a wrap corrupts every later stamp: the first record reads non-zero at once, and a wrap fault appears one roll-over (65,536 cycles) after the first edge. Arbitration or pending-hold faults show as swapped or missing neighbours in a table two to three cycles after simultaneous or closely spaced edges. Write-index or overflow faults appear only after the 193rd record of a direction.

// File: rtl/esr_pkg.sv
`timescale 1ns/1ps
package esr_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2
    } esr_state_e;

    typedef enum logic {
        TBL_FALL = 1'b0,
        TBL_RISE = 1'b1
    } esr_tbl_e;
endpackage

// File: rtl/esr_edge_track.sv
`timescale 1ns/1ps
module esr_edge_track #(
    parameter int TICK_W   = 16,
    parameter int WRAP_W   = 16,
    parameter int CFG_W    = 8,
    parameter int EN_BIT   = 7,
    parameter int RISE_BIT = 6,
    parameter int FALL_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic              live,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              sig,
    input  logic              grant,
    input  logic [TICK_W-1:0] stamp_tick,
    input  logic [WRAP_W-1:0] stamp_wrap,
    output logic              accept,
    output logic              pend,
    output logic              pend_rise,
    output logic [TICK_W-1:0] pend_tick,
    output logic [WRAP_W-1:0] pend_wrap
);
    logic              sig_q;
    logic              en_q;
    logic              arm_rise_q;
    logic              pend_q;
    logic              pend_rise_q;
    logic [TICK_W-1:0] pend_tick_q;
    logic [WRAP_W-1:0] pend_wrap_q;
    logic              saw_rise;
    logic              saw_fall;
    logic              hit;
    logic              cfg_unused_parity;

    assign cfg_unused_parity = ^cfg;

    always_comb begin
        saw_rise = sig & ~sig_q;
        saw_fall = ~sig & sig_q;
        hit      = arm_rise_q ? saw_rise : saw_fall;
        accept   = live & en_q & ~pend_q & hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q      <= 1'b0;
            en_q       <= 1'b0;
            arm_rise_q <= 1'b0;
        end else begin
            sig_q <= sig;
            if (load) begin
                en_q <= cfg[EN_BIT];
                if (cfg[RISE_BIT])
                    arm_rise_q <= 1'b1;
                else if (cfg[FALL_BIT])
                    arm_rise_q <= 1'b0;
            end else if (accept) begin
                arm_rise_q <= ~arm_rise_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_rise_q <= 1'b0;
            pend_tick_q <= '0;
            pend_wrap_q <= '0;
        end else if (flush) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q      <= 1'b1;
            pend_rise_q <= arm_rise_q;
            pend_tick_q <= stamp_tick;
            pend_wrap_q <= stamp_wrap;
        end else if (grant) begin
            pend_q <= 1'b0;
        end
    end

    assign pend      = pend_q;
    assign pend_rise = pend_rise_q;
    assign pend_tick = pend_tick_q;
    assign pend_wrap = pend_wrap_q;

    // R6: the armed direction swaps after every capture
    assert_dir_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !load) |=> (arm_rise_q != $past(arm_rise_q)));

    // R8: a pending record stays put until granted
    assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !grant && !flush) |=> (pend_q && $stable(pend_tick_q) && $stable(pend_wrap_q)));

    // R3: a disabled channel holds no record
    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pend_q);
endmodule

// File: rtl/esr_timebase.sv
`timescale 1ns/1ps
module esr_timebase #(
    parameter int TICK_W = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero,
    input  logic              run,
    output logic [TICK_W-1:0] tick,
    output logic [WRAP_W-1:0] wrap
);
    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    logic [TICK_W-1:0] tick_q;
    logic [WRAP_W-1:0] wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            wrap_q <= '0;
        end else if (zero) begin
            tick_q <= '0;
            wrap_q <= '0;
        end else if (run) begin
            if (tick_q == TICK_MAX) begin
                tick_q <= '0;
                wrap_q <= wrap_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign tick = tick_q;
    assign wrap = wrap_q;

    // R5: a roll-over advances the wrap count by one
    assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !zero && tick_q == TICK_MAX) |=>
            (tick_q == '0 && wrap_q == WRAP_W'($past(wrap_q) + 1'b1)));

    // R4: time does not move while stopped
    assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !zero) |=> ($stable(tick_q) && $stable(wrap_q)));
endmodule

// File: rtl/esr_table.sv
`timescale 1ns/1ps
module esr_table #(
    parameter int DEPTH = 192,
    parameter int REC_W = 34,
    parameter int AW    = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep,
    input  logic [AW-1:0]    sweep_addr,
    input  logic             wr_en,
    input  logic [REC_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [REC_W-1:0] rd_data,
    output logic             ovf
);
    localparam logic [IDX_W-1:0] FULL    = IDX_W'(DEPTH);
    localparam logic [AW:0]      DEPTH_V = (AW+1)'(DEPTH);

    logic [REC_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic             ovf_q;
    logic             room;
    logic [AW-1:0]    wr_addr;

    assign room    = (idx_q < FULL);
    assign wr_addr = idx_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ovf_q <= 1'b0;
        end else if (sweep) begin
            idx_q <= '0;
            ovf_q <= 1'b0;
        end else if (wr_en) begin
            if (room)
                idx_q <= idx_q + 1'b1;
            else
                ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (sweep)
            mem[sweep_addr] <= '0;
        else if (wr_en && room)
            mem[wr_addr] <= wr_data;
    end

    always_comb begin
        if ({1'b0, rd_addr} < DEPTH_V)
            rd_data = mem[rd_addr];
        else
            rd_data = '0;
    end

    assign ovf = ovf_q;

    // R9: overflow flag is sticky until the next sweep
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !sweep) |=> ovf_q);

    // R9: write index never passes the table size
    assert_idx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= FULL);

    // R9: a write into a full table raises the flag
    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sweep && idx_q == FULL) |=> ovf_q);
endmodule

// File: rtl/edge_stamp_recorder.sv
`timescale 1ns/1ps
module edge_stamp_recorder
    import esr_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int DEPTH    = 192,
    parameter int TICK_W   = 16,
    parameter int WRAP_W   = 16,
    parameter int CFG_W    = 8,
    parameter int CNT_W    = 16,
    parameter int EN_BIT   = 7,
    parameter int RISE_BIT = 6,
    parameter int FALL_BIT = 5,
    localparam int ID_W    = $clog2(NUM_CH + 1),
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [NUM_CH-1:0]       ch_in,
    input  logic [NUM_CH*CFG_W-1:0] cfg_bus,
    input  logic                    rd_table,
    input  logic [AW-1:0]           rd_addr,
    output logic                    busy,
    output logic [ID_W-1:0]         rd_chan,
    output logic [WRAP_W-1:0]       rd_wrap,
    output logic [TICK_W-1:0]       rd_tick,
    output logic [CNT_W-1:0]        event_total,
    output logic                    ovf_fall,
    output logic                    ovf_rise
);
    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam int REC_W = ID_W + WRAP_W + TICK_W;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    esr_state_e state_q, state_d;
    logic [AW-1:0]     sweep_q;
    logic              sweeping, load, live, run;
    logic [NUM_CH-1:0] acc, pend, pend_rise, grant;
    logic [TICK_W-1:0] pend_tick [NUM_CH];
    logic [WRAP_W-1:0] pend_wrap [NUM_CH];
    logic [TICK_W-1:0] tb_tick;
    logic [WRAP_W-1:0] tb_wrap;
    logic [REC_W-1:0]  wr_rec, fall_rd, rise_rd, sel_rd;
    logic              wr_is_rise, wr_any;
    logic [CNT_W-1:0]  total_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (clear)
                    state_d = ST_CLEAR;
                else if (sweep_q == LAST)
                    state_d = ST_ARM;
            end
            ST_ARM: begin
                if (clear)
                    state_d = ST_CLEAR;
                else if (|acc)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (clear)
                    state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // state-driven outputs
    always_comb begin
        sweeping = (state_q == ST_CLEAR);
        load     = sweeping && !clear && (sweep_q == LAST);
        live     = !sweeping;
        run      = (state_q == ST_RUN) || ((state_q == ST_ARM) && (|acc));
        busy     = sweeping;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sweep_q <= '0;
        else if (clear || state_q != ST_CLEAR)
            sweep_q <= '0;
        else if (sweep_q != LAST)
            sweep_q <= sweep_q + 1'b1;
    end

    esr_timebase #(.TICK_W(TICK_W), .WRAP_W(WRAP_W)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .zero (sweeping),
        .run  (run),
        .tick (tb_tick),
        .wrap (tb_wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        esr_edge_track #(
            .TICK_W(TICK_W), .WRAP_W(WRAP_W), .CFG_W(CFG_W),
            .EN_BIT(EN_BIT), .RISE_BIT(RISE_BIT), .FALL_BIT(FALL_BIT)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (sweeping),
            .load      (load),
            .live      (live),
            .cfg       (cfg_bus[g*CFG_W +: CFG_W]),
            .sig       (ch_in[g]),
            .grant     (grant[g]),
            .stamp_tick(tb_tick),
            .stamp_wrap(tb_wrap),
            .accept    (acc[g]),
            .pend      (pend[g]),
            .pend_rise (pend_rise[g]),
            .pend_tick (pend_tick[g]),
            .pend_wrap (pend_wrap[g])
        );
    end

    // fixed-priority writer: lowest channel number first
    always_comb begin
        logic found;
        found      = 1'b0;
        grant      = '0;
        wr_rec     = '0;
        wr_is_rise = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (pend[i] && !found) begin
                found      = 1'b1;
                grant[i]   = 1'b1;
                wr_rec     = {ID_W'(i + 1), pend_wrap[i], pend_tick[i]};
                wr_is_rise = pend_rise[i];
            end
        end
        wr_any = found;
    end

    esr_table #(.DEPTH(DEPTH), .REC_W(REC_W), .AW(AW), .IDX_W(IDX_W)) u_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep     (sweeping),
        .sweep_addr(sweep_q),
        .wr_en     (wr_any && !wr_is_rise),
        .wr_data   (wr_rec),
        .rd_addr   (rd_addr),
        .rd_data   (fall_rd),
        .ovf       (ovf_fall)
    );

    esr_table #(.DEPTH(DEPTH), .REC_W(REC_W), .AW(AW), .IDX_W(IDX_W)) u_rise (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep     (sweeping),
        .sweep_addr(sweep_q),
        .wr_en     (wr_any && wr_is_rise),
        .wr_data   (wr_rec),
        .rd_addr   (rd_addr),
        .rd_data   (rise_rd),
        .ovf       (ovf_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            total_q <= '0;
        else if (sweeping)
            total_q <= '0;
        else
            total_q <= total_q + CNT_W'($countones(acc));
    end

    assign sel_rd      = (rd_table == TBL_RISE) ? rise_rd : fall_rd;
    assign rd_chan     = sel_rd[REC_W-1 -: ID_W];
    assign rd_wrap     = sel_rd[TICK_W +: WRAP_W];
    assign rd_tick     = sel_rd[TICK_W-1:0];
    assign event_total = total_q;

    // R8: at most one record written per cycle
    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: time base is parked at zero while waiting for the first edge
    assert_arm_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> (tb_tick == '0 && tb_wrap == '0));

    // R1: a sweep cycle leaves the total at zero
    assert_clear_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (total_q == '0));
endmodule

// File: tb/edge_stamp_recorder_tb.sv
`timescale 1ns/1ps
module edge_stamp_recorder_tb;
    localparam int DEPTH = 192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [2:0]  ch_in = 3'b101;
    logic [23:0] cfg_bus = {8'h60, 8'hC0, 8'hA0};
    logic        rd_table = 1'b0;
    logic [7:0]  rd_addr = 8'd0;
    logic        busy;
    logic [1:0]  rd_chan;
    logic [15:0] rd_wrap;
    logic [15:0] rd_tick;
    logic [15:0] event_total;
    logic        ovf_fall;
    logic        ovf_rise;

    edge_stamp_recorder u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ch_in(ch_in), .cfg_bus(cfg_bus),
        .rd_table(rd_table), .rd_addr(rd_addr), .busy(busy), .rd_chan(rd_chan),
        .rd_wrap(rd_wrap), .rd_tick(rd_tick), .event_total(event_total),
        .ovf_fall(ovf_fall), .ovf_rise(ovf_rise)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc = cyc + 1;

    // scoreboard model state
    logic [33:0] fall_q[$];
    logic [33:0] rise_q[$];
    bit m_en[3];
    bit m_rise[3];
    int m_free[3];
    int first_cyc;
    int n_fall, n_rise, base_f, base_r, exp_total;
    bit exp_ovf_f, exp_ovf_r, in_clear;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_apply();
        for (int k = 0; k < 3; k++) begin
            m_en[k] = cfg_bus[k*8+7];
            if (cfg_bus[k*8+6]) m_rise[k] = 1'b1;
            else if (cfg_bus[k*8+5]) m_rise[k] = 1'b0;
            m_free[k] = 0;
        end
        first_cyc = -1;
        n_fall = 0; n_rise = 0; base_f = 0; base_r = 0; exp_total = 0;
        exp_ovf_f = 1'b0; exp_ovf_r = 1'b0;
        fall_q.delete(); rise_q.delete();
    endtask

    // driver: changes the lines and pushes the records the requirements predict
    task automatic drive(input logic [2:0] nv);
        int c, rank, st;
        bit rs;
        logic [33:0] rec;
        @(negedge clk);
        c = cyc + 1;
        rank = 0;
        for (int k = 0; k < 3; k++) begin
            if (nv[k] != ch_in[k] && !in_clear) begin
                rs = nv[k];
                if (m_en[k] && m_rise[k] == rs && c >= m_free[k]) begin
                    if (first_cyc < 0) first_cyc = c;
                    st  = c - first_cyc;
                    rec = {2'(k + 1), 16'(st / 65536), 16'(st % 65536)};
                    if (rs) begin
                        if (n_rise < DEPTH) begin rise_q.push_back(rec); n_rise++; end
                        else exp_ovf_r = 1'b1;
                    end else begin
                        if (n_fall < DEPTH) begin fall_q.push_back(rec); n_fall++; end
                        else exp_ovf_f = 1'b1;
                    end
                    exp_total++;
                    m_rise[k] = ~m_rise[k];
                    m_free[k] = c + 2 + rank;
                    rank++;
                end
            end
        end
        ch_in = nv;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_rec(input bit t, input int a, output logic [33:0] r);
        @(negedge clk);
        rd_table = t;
        rd_addr  = a[7:0];
        #1;
        r = {rd_chan, rd_wrap, rd_tick};
    endtask

    // monitor: pops expected records and compares them with the tables
    task automatic drain(input string req);
        logic [33:0] got, exp;
        idle(4);
        while (fall_q.size() > 0) begin
            exp = fall_q.pop_front();
            read_rec(1'b0, base_f, got);
            check(got == exp, {req, " falling table"}, 64'(got), 64'(exp));
            base_f++;
        end
        while (rise_q.size() > 0) begin
            exp = rise_q.pop_front();
            read_rec(1'b1, base_r, got);
            check(got == exp, {req, " rising table"}, 64'(got), 64'(exp));
            base_r++;
        end
        check(event_total == 16'(exp_total), "R10 total", 64'(event_total), 64'(exp_total));
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (busy && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy, "R1 sweep ends", 64'(busy), 64'(0));
    endtask

    task automatic check_empty(input string req);
        logic [33:0] got;
        read_rec(1'b0, 0, got);           check(got == 0, req, 64'(got), 64'(0));
        read_rec(1'b0, DEPTH - 1, got);   check(got == 0, req, 64'(got), 64'(0));
        read_rec(1'b1, 0, got);           check(got == 0, req, 64'(got), 64'(0));
        read_rec(1'b1, DEPTH - 1, got);   check(got == 0, req, 64'(got), 64'(0));
        check(event_total == 0, req, 64'(event_total), 64'(0));
        check(!ovf_fall && !ovf_rise, req, 64'({ovf_fall, ovf_rise}), 64'(0));
    endtask

    task automatic do_clear(input bit toggle_during);
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check(busy, "R1 busy after clear", 64'(busy), 64'(1));
        if (toggle_during) begin
            in_clear = 1'b1;
            drive(ch_in ^ 3'b001);
            idle(3);
            drive(ch_in ^ 3'b001);
            idle(3);
            in_clear = 1'b0;
        end
        wait_ready();
        model_apply();
    endtask

    initial begin
        logic [33:0] got;
        in_clear = 1'b0;
        for (int k = 0; k < 3; k++) m_rise[k] = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy, "R1 busy after reset", 64'(busy), 64'(1));
        wait_ready();
        model_apply();
        check_empty("R1 reset state");

        // disabled channel 3 moves: nothing recorded
        idle(7);
        drive(3'b001);
        idle(4);
        check(event_total == 0, "R3 disabled channel", 64'(event_total), 64'(0));
        // first edge is falling on channel 1 (R4), then channel 2 rises and falls (R7)
        drive(3'b000); idle(5);
        drive(3'b010); idle(5);
        drive(3'b000); idle(4);
        // R8: edge while pending ignored; R6: unarmed direction ignored
        drive(3'b001);
        drive(3'b000); idle(4);
        drive(3'b001); idle(4);
        drive(3'b000); idle(4);
        // R8: simultaneous rising edges on channels 1 and 2
        drive(3'b011); idle(5);
        // R2: configuration change without a clear has no effect
        cfg_bus = {8'h80, 8'h00, 8'hE0};
        drive(3'b111); idle(4);
        drain("R4 R7 R8 R6 R2");

        // R11: edges during the sweep are dropped; new config now in force
        do_clear(1'b1);
        check_empty("R11 after clear");
        drive(3'b110); idle(4);   // R2 rising wins, falling ignored
        drive(3'b111); idle(4);
        drive(3'b011); idle(4);   // channel 3 kept rising direction
        drive(3'b111); idle(4);
        drain("R2 R3 reconfigured");

        // R5: roll-over of the tick counter
        do_clear(1'b0);
        drive(3'b110); idle(2);
        drive(3'b111);
        idle(65540);
        drive(3'b110);
        drain("R5 wrap");

        // R9 R10: both tables overflow
        do_clear(1'b0);
        for (int n = 0; n < 400; n++) begin
            drive(ch_in ^ 3'b001);
            idle(1);
        end
        drain("R9 full tables");
        check(ovf_fall == exp_ovf_f, "R9 falling overflow", 64'(ovf_fall), 64'(exp_ovf_f));
        check(ovf_rise == exp_ovf_r, "R9 rising overflow", 64'(ovf_rise), 64'(exp_ovf_r));
        idle(6);
        check(ovf_fall && ovf_rise, "R9 sticky", 64'({ovf_fall, ovf_rise}), 64'(3));
        read_rec(1'b1, 200, got);
        check(got == 0, "R12 address past end", 64'(got), 64'(0));

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-sequence: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule